// File: doc/BRIEF.md
# Pipelined Carry-Save Sixteen-Operand Summer

This block adds sixteen signed operands into one two's-complement total. Each operand is sign-extended to the result width. The operands then pass through three levels of 4:2 compressors: sixteen vectors become eight, then four, then two. Every intermediate value stays in redundant carry-save form. A register sits after each compressor level. The last two vectors are added by a logarithmic-depth parallel-prefix adder, so no carry ripples along the word. The adder output is registered before it reaches the port.

Operands enter as one flat bus with a valid/ready handshake, and the total leaves through a second valid/ready pair. An item moves across either interface only on a rising edge where both valid and ready are high. Back-pressure works as one freeze for the whole pipeline. When the output holds a result that the consumer has not taken (`res_vld` high and `res_rdy` low), every stage holds its contents and `ops_rdy` goes low. In every other cycle, all stages advance together and the block accepts input. The consumer may hold `res_rdy` low for any number of cycles.

Top module: `csa_tree_sum`

## Requirements
- R1: The total equals the sum of the sixteen operands, wrapped to 16 bits in two's complement. Operand k is the 12-bit signed field at `ops_bus[12k+11:12k]`, and the total is presented on `res_sum` as a signed 16-bit value.
- R2: The corner cases are exact. Sixteen operands of +2047 give 32752 (0x7FF0), and sixteen operands of -2048 give -32768 (0x8000).
- R3: The latency is four edges, with `res_rdy` held high. An operand set is accepted on one rising edge, and its total shows on `res_sum` with `res_vld` high right after the fourth rising edge, counting the accepting edge as the first.
- R4: `ops_rdy` is high exactly when `res_vld` is low or `res_rdy` is high.
- R5: While `res_vld` is high and `res_rdy` is low, `res_vld` and `res_sum` keep their values on the next edge.
- R6: Every accepted operand set yields exactly one total, in acceptance order. No total appears without an accepted set, and at most four sets are in flight at once.
- R7: During and right after synchronous reset (`rst` high), `res_vld` is low and the pipeline holds no items.
- R8: In a cycle where `ops_vld` is low, the value on `ops_bus` is ignored and produces no total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ops_vld | input | 1 | Operand set on `ops_bus` is valid |
| ops_rdy | output | 1 | Block can take an operand set this cycle |
| ops_bus | input | 192 | Sixteen packed 12-bit signed operands, operand 0 in the low bits |
| res_vld | output | 1 | `res_sum` holds a total |
| res_rdy | input | 1 | Consumer takes the total this cycle |
| res_sum | output | 16 | Registered signed total |

## Verification
The assertions assume the producer never drives `ops_vld` or `res_rdy` to an unknown value once reset is released. They also assume that `rst` is held for at least one edge at start-up, so the in-flight count starts at zero. The stimulus drives both handshake inputs at falling edges, to defined levels only. It keeps `rst` high for several edges before any traffic. It mixes a stretch with `res_rdy` always high against a stretch with pseudo-random back-pressure, so that both the stall hold and the full-speed path are exercised.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int unsigned CTS_N_OPS = 16;
  localparam int unsigned CTS_IN_W  = 12;
  localparam int unsigned CTS_OUT_W = 16;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/cts_comp42.sv
// Vector 4:2 compressor: a+b+c+d == s+cy (mod 2^W). The horizontal carry
// of each bit depends only on a,b,c so it never chains across bits.
module cts_comp42
  import cts_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);
  logic [W-1:0] fa1_s;
  logic [W-1:0] hz;     // horizontal carry into bit i
  logic [W-1:0] vc;     // second full adder carry out of bit i
  logic         unused_top;

  assign hz[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign fa1_s[i] = a[i] ^ b[i] ^ c[i];
    if (i < W - 1) begin : g_hz
      assign hz[i+1] = maj3(a[i], b[i], c[i]);
    end
    assign s[i]  = fa1_s[i] ^ d[i] ^ hz[i];
    assign vc[i] = maj3(fa1_s[i], d[i], hz[i]);
  end

  assign cy         = {vc[W-2:0], 1'b0};
  assign unused_top = vc[W-1] ^ maj3(a[W-1], b[W-1], c[W-1]);
endmodule

// File: rtl/cts_level.sv
// One compressor level: N_IN vectors in, N_IN/2 vectors out.
module cts_level #(
  parameter int unsigned W    = 16,
  parameter int unsigned N_IN = 16
) (
  input  logic [N_IN-1:0][W-1:0]   din,
  output logic [N_IN/2-1:0][W-1:0] dout
);
  localparam int unsigned GROUPS = N_IN / 4;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    cts_comp42 #(.W(W)) u_c42 (
      .a (din[4*g]),
      .b (din[4*g+1]),
      .c (din[4*g+2]),
      .d (din[4*g+3]),
      .s (dout[2*g]),
      .cy(dout[2*g+1])
    );
  end
endmodule

// File: rtl/cts_prefix_add.sv
// Logarithmic-depth generate/propagate adder, carry-in zero, wraps at W bits.
module cts_prefix_add #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  localparam int unsigned LOG = $clog2(W);

  logic [LOG:0][W-1:0] gg;
  logic [LOG:0][W-1:0] pp;
  logic                unused_pg;

  assign gg[0] = a & b;
  assign pp[0] = a ^ b;

  for (genvar l = 1; l <= LOG; l++) begin : g_lvl
    localparam int unsigned DIST = 1 << (l - 1);
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= DIST) begin : g_cmb
        assign gg[l][i] = gg[l-1][i] | (pp[l-1][i] & gg[l-1][i-DIST]);
        assign pp[l][i] = pp[l-1][i] & pp[l-1][i-DIST];
      end else begin : g_pass
        assign gg[l][i] = gg[l-1][i];
        assign pp[l][i] = pp[l-1][i];
      end
    end
  end

  assign s[0] = pp[0][0];
  for (genvar i = 1; i < W; i++) begin : g_sum
    assign s[i] = pp[0][i] ^ gg[LOG][i-1];
  end

  assign unused_pg = ^{pp[LOG], gg[LOG][W-1]};
endmodule

// File: rtl/csa_tree_sum.sv
module csa_tree_sum
  import cts_pkg::*;
#(
  parameter int unsigned N_OPS = CTS_N_OPS,
  parameter int unsigned IN_W  = CTS_IN_W,
  parameter int unsigned OUT_W = CTS_OUT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ops_vld,
  output logic                  ops_rdy,
  input  logic [N_OPS*IN_W-1:0] ops_bus,
  output logic                  res_vld,
  input  logic                  res_rdy,
  output logic [OUT_W-1:0]      res_sum
);
  localparam int unsigned LEVELS = $clog2(N_OPS) - 1;
  localparam int unsigned EXT_W  = OUT_W - IN_W;

  logic                         adv;
  logic [N_OPS-1:0][OUT_W-1:0]  ext;
  logic [OUT_W-1:0]             sum_c;

  // the whole pipeline moves as one when the output slot is free or taken
  assign adv     = !res_vld || res_rdy;
  assign ops_rdy = adv;

  for (genvar k = 0; k < N_OPS; k++) begin : g_ext
    assign ext[k] = {{EXT_W{ops_bus[k*IN_W+IN_W-1]}}, ops_bus[k*IN_W +: IN_W]};
  end

  for (genvar j = 0; j < LEVELS; j++) begin : g_stg
    localparam int unsigned NI = N_OPS >> j;
    logic [NI-1:0][OUT_W-1:0]   d_in;
    logic [NI/2-1:0][OUT_W-1:0] d_out;
    logic [NI/2-1:0][OUT_W-1:0] q;
    logic                       v_in;
    logic                       v_q;

    if (j == 0) begin : g_first
      assign d_in = ext;
      assign v_in = ops_vld;
    end else begin : g_next
      assign d_in = g_stg[j-1].q;
      assign v_in = g_stg[j-1].v_q;
    end

    cts_level #(.W(OUT_W), .N_IN(NI)) u_lvl (
      .din (d_in),
      .dout(d_out)
    );

    always_ff @(posedge clk) begin
      if (adv) q <= d_out;
    end

    always_ff @(posedge clk) begin
      if (rst)      v_q <= 1'b0;
      else if (adv) v_q <= v_in;
    end
  end

  cts_prefix_add #(.W(OUT_W)) u_fin (
    .a(g_stg[LEVELS-1].q[0]),
    .b(g_stg[LEVELS-1].q[1]),
    .s(sum_c)
  );

  always_ff @(posedge clk) begin
    if (adv) res_sum <= sum_c;
  end

  always_ff @(posedge clk) begin
    if (rst)      res_vld <= 1'b0;
    else if (adv) res_vld <= g_stg[LEVELS-1].v_q;
  end
endmodule

// File: rtl/csa_tree_sum_chk.sv
module csa_tree_sum_chk #(
  parameter int unsigned OUT_W = 16,
  parameter int unsigned DEPTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ops_vld,
  input logic             ops_rdy,
  input logic             res_vld,
  input logic             res_rdy,
  input logic [OUT_W-1:0] res_sum
);
  logic [7:0] occ;
  logic       acc_in;
  logic       acc_out;

  assign acc_in  = ops_vld && ops_rdy;
  assign acc_out = res_vld && res_rdy;

  always_ff @(posedge clk) begin
    if (rst) occ <= 8'd0;
    else     occ <= occ + {7'd0, acc_in} - {7'd0, acc_out};
  end

  a_r7_reset_empty: assert property (@(posedge clk) rst |=> !res_vld);

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !res_rdy) |=> (res_vld && $stable(res_sum)));

  a_r4_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> ops_rdy);

  a_r4_block_on_stall: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !res_rdy) |-> !ops_rdy);

  a_r6_bounded_flight: assert property (@(posedge clk) disable iff (rst)
    occ <= 8'(DEPTH));

  a_r6_no_phantom: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> (occ != 8'd0));
endmodule

bind csa_tree_sum csa_tree_sum_chk #(.OUT_W(OUT_W), .DEPTH($clog2(N_OPS))) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ops_vld(ops_vld),
  .ops_rdy(ops_rdy),
  .res_vld(res_vld),
  .res_rdy(res_rdy),
  .res_sum(res_sum)
);

// File: tb/csa_tree_sum_bench.sv
`timescale 1ns/1ps
module csa_tree_sum_bench;
  localparam int N  = 16;
  localparam int IW = 12;
  localparam int OW = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ops_vld = 1'b0;
  logic              ops_rdy;
  logic [N*IW-1:0]   ops_bus = '0;
  logic              res_vld;
  logic              res_rdy = 1'b1;
  logic [OW-1:0]     res_sum;

  int                total = 0;
  int                bad = 0;
  int                bp_mode = 0;
  logic [OW-1:0]     expq[$];
  logic              prev_stall = 1'b0;
  logic [OW-1:0]     prev_sum = '0;
  logic              mon_on = 1'b0;
  logic              finished = 1'b0;

  always #5 clk = ~clk;

  csa_tree_sum u_csa_tree_sum (
    .clk(clk), .rst(rst), .ops_vld(ops_vld), .ops_rdy(ops_rdy), .ops_bus(ops_bus),
    .res_vld(res_vld), .res_rdy(res_rdy), .res_sum(res_sum)
  );

  function automatic logic [OW-1:0] ref_sum(input logic [N*IW-1:0] ops);
    int acc = 0;
    for (int k = 0; k < N; k++) acc += int'($signed(ops[k*IW +: IW]));
    return acc[OW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [N*IW-1:0] ops);
    @(negedge clk);
    ops_vld = 1'b1;
    ops_bus = ops;
    #1;
    while (!ops_rdy) begin
      @(negedge clk);
      #1;
    end
    expq.push_back(ref_sum(ops));
    @(posedge clk);
    #1 ops_vld = 1'b0;
  endtask

  function automatic logic [N*IW-1:0] fill(input logic [IW-1:0] v);
    logic [N*IW-1:0] r;
    for (int k = 0; k < N; k++) r[k*IW +: IW] = v;
    return r;
  endfunction

  function automatic logic [N*IW-1:0] rnd_ops();
    logic [N*IW-1:0] r;
    for (int k = 0; k < N; k++) r[k*IW +: IW] = IW'($urandom);
    return r;
  endfunction

  // back-pressure source
  always @(negedge clk) begin
    if (bp_mode == 0) res_rdy <= 1'b1;
    else              res_rdy <= (($urandom % 3) != 0);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      // R4: ready follows output slot state
      chk(ops_rdy == (!res_vld || res_rdy), "R4", int'(ops_rdy), int'(!res_vld || res_rdy));
      // R5: stalled output holds
      if (prev_stall)
        chk(res_vld && res_sum == prev_sum, "R5", int'(res_sum), int'(prev_sum));
      if (res_vld && res_rdy) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R6/R8 unexpected total", int'(res_sum), 0);
        end else begin
          logic [OW-1:0] e;
          e = expq.pop_front();
          chk(res_sum == e, "R1", int'(res_sum), int'(e));
        end
      end
      prev_stall = res_vld && !res_rdy;
      prev_sum   = res_sum;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (4) @(negedge clk);
    // R7: outputs in reset
    chk(res_vld == 1'b0, "R7 vld in reset", int'(res_vld), 0);
    chk(ops_rdy == 1'b1, "R7 rdy in reset", int'(ops_rdy), 1);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(res_vld == 1'b0, "R7 vld after reset", int'(res_vld), 0);
    mon_on = 1'b1;

    // R3: latency on an empty pipeline with res_rdy high
    @(negedge clk);
    ops_vld = 1'b1;
    ops_bus = fill(12'd5);
    expq.push_back(ref_sum(fill(12'd5)));
    @(negedge clk);
    ops_vld = 1'b0;
    lat = 1;
    #3;
    while (!res_vld && lat < 20) begin
      @(negedge clk);
      #3;
      lat++;
    end
    chk(lat == 4, "R3 latency", lat, 4);
    chk(res_sum == 16'd80, "R3 value", int'(res_sum), 80);
    repeat (3) @(negedge clk);

    // R2: extremes
    send(fill(12'h7FF));
    send(fill(12'h800));
    repeat (6) @(negedge clk);
    // R2 direct port look at the last total
    chk(res_sum == 16'h8000, "R2 all-min", int'(res_sum), 32'h8000);

    // R8: garbage with valid low yields nothing
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      ops_bus = rnd_ops();
      #3;
      chk(expq.size() != 0 || !res_vld || res_sum == 16'h8000, "R8 idle", int'(res_vld), 0);
    end
    chk(expq.size() == 0, "R8 queue drained", expq.size(), 0);

    // R1: patterns, back-to-back, then R5/R6 under back-pressure
    send(fill(12'h7FF));
    send(fill(12'h001));
    send(fill(12'hFFF));
    send({{8{12'h7FF}}, {8{12'h800}}});
    for (int t = 0; t < 40; t++) send(rnd_ops());
    bp_mode = 1;
    for (int t = 0; t < 200; t++) send(rnd_ops());
    send(fill(12'h800));
    send(fill(12'h7FF));
    begin
      int w = 0;
      while (expq.size() != 0 && w < 2000) begin
        @(negedge clk);
        w++;
      end
    end
    bp_mode = 0;
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R6 all totals delivered", expq.size(), 0);
    chk(res_vld == 1'b0 || res_rdy, "R6 idle end", int'(res_vld), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule